// File: doc/BRIEF.md
# Binary Time-of-Year Counter with Microsecond Resolution

This block keeps a time of year as a binary tag of five separate fields: day of year, hour, minute, second and microsecond. An external prescaler pulses a tick input once per microsecond. With no external time source present, the counter simply keeps counting from its last value, carrying from one field into the next. Software can set a start time through a small word-wide register port. A time-code frame decoder, when one is present, can resynchronise the count by presenting decoded day, hour, minute and second values together with a strobe.

The 46-bit tag is read as two 32-bit words. Reading the low word captures the high word at the same moment, so a read of the high word that follows returns the same instant even if the count has moved on. A one-cycle pulse marks each rollover of the microsecond field, and a time-code encoder can use it as its seconds reference.

Top module: `time_of_year_counter`

## Requirements
- R1: The microsecond field increases by exactly one at each clock edge where `tick_us` is high and no load takes place. Without a tick or a load, all five fields hold their values.
- R2: The microsecond field goes from 999999 to 0 and carries one into the second field. The second field goes from 59 to 0 and carries into the minute field. The minute field goes from 59 to 0 and carries into the hour field.
- R3: The hour field goes from 23 to 0 and carries into the day field. With `leap_year` low, day 365 is followed by day 1. With `leap_year` high, day 365 is followed by day 366, and day 366 is followed by day 1.
- R4: A write to address 1 only stages a high word; it leaves the count unchanged. The staged word holds the day in bits [13:5] and the hour in bits [4:0]. A write to address 0 loads the whole tag: day and hour come from the staged word, and `bus_wdata` supplies minute [31:26], second [25:20] and microsecond [19:0].
- R5: When `sync_stb` is high, the next edge loads the four sync fields and clears the microsecond field. This load takes priority over a tick in the same cycle, and no seconds pulse follows from that edge.
- R6: `sec_pulse` is high for exactly one cycle. That cycle is the one right after the clock edge at which a tick rolls the microsecond field from 999999 to 0.
- R7: With `bus_addr` = 0, `bus_rdata` returns the live low word {minute, second, microsecond}, packed as in R4. A cycle with `bus_rd` high and `bus_addr` = 0 captures {day, hour}. With `bus_addr` = 1, `bus_rdata` returns that captured value in bits [13:0], with zeros above.
- R8: After reset the tag is day 1, hour 0, minute 0, second 0, microsecond 0. `sec_pulse` is low, and the captured high word is zero.
- R9: A write to address 0 takes priority over `sync_stb` and over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| leap_year | input | 1 | Selects a 366-day year |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Word select: 0 low word, 1 high word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| sync_stb | input | 1 | Decoded-frame load strobe |
| sync_day | input | 9 | Decoded day of year |
| sync_hour | input | 5 | Decoded hour |
| sync_min | input | 6 | Decoded minute |
| sync_sec | input | 6 | Decoded second |
| sec_pulse | output | 1 | One-cycle pulse on microsecond rollover |

## Verification
Two functions can fall in the same cycle: a tick and a decoded-frame load. The bench raises `sync_stb` together with `tick_us`, both on an ordinary count and on a count at 999999. It then expects the sync fields with the microsecond field cleared, and no seconds pulse. A software low-word write is also driven together with both the strobe and the tick, and the bench judges that the written value wins.

// File: rtl/time_of_year_counter.sv
module time_of_year_counter #(
  parameter int US_PER_SEC  = 1000000,
  parameter int DAYS_NORMAL = 365
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        leap_year,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        sync_stb,
  input  logic [8:0]  sync_day,
  input  logic [4:0]  sync_hour,
  input  logic [5:0]  sync_min,
  input  logic [5:0]  sync_sec,
  output logic        sec_pulse
);

  localparam logic [19:0] US_LAST  = 20'(US_PER_SEC - 1);
  localparam logic [8:0]  DAY_NORM = 9'(DAYS_NORMAL);

  logic [8:0]  day_q;
  logic [4:0]  hour_q;
  logic [5:0]  min_q, sec_q;
  logic [19:0] us_q;
  logic [13:0] hi_stage_q, hi_snap_q;

  logic sw_load, advance;
  logic us_last, sec_last, min_last, hour_last, day_last;
  logic [8:0] day_top;

  assign sw_load   = bus_wr && !bus_addr;
  assign advance   = tick_us && !sw_load && !sync_stb;
  assign day_top   = leap_year ? DAY_NORM + 9'd1 : DAY_NORM;
  assign us_last   = us_q >= US_LAST;
  assign sec_last  = sec_q >= 6'd59;
  assign min_last  = min_q >= 6'd59;
  assign hour_last = hour_q >= 5'd23;
  assign day_last  = day_q >= day_top;

  assign bus_rdata = bus_addr ? {18'd0, hi_snap_q} : {min_q, sec_q, us_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q  <= 9'd1;
      hour_q <= '0;
      min_q  <= '0;
      sec_q  <= '0;
      us_q   <= '0;
    end else if (sw_load) begin
      {day_q, hour_q}       <= hi_stage_q;
      {min_q, sec_q, us_q}  <= bus_wdata;
    end else if (sync_stb) begin
      day_q  <= sync_day;
      hour_q <= sync_hour;
      min_q  <= sync_min;
      sec_q  <= sync_sec;
      us_q   <= '0;
    end else if (advance) begin
      us_q <= us_last ? '0 : us_q + 20'd1;
      if (us_last) begin
        sec_q <= sec_last ? '0 : sec_q + 6'd1;
        if (sec_last) begin
          min_q <= min_last ? '0 : min_q + 6'd1;
          if (min_last) begin
            hour_q <= hour_last ? '0 : hour_q + 5'd1;
            if (hour_last) day_q <= day_last ? 9'd1 : day_q + 9'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      hi_snap_q  <= '0;
      sec_pulse  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr) hi_stage_q <= bus_wdata[13:0];
      if (bus_rd && !bus_addr) hi_snap_q <= {day_q, hour_q};
      sec_pulse <= advance && us_last;
    end
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !us_last) |=> us_q == $past(us_q) + 20'd1); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !sync_stb && !bus_wr) |=> $stable({day_q, hour_q, min_q, sec_q, us_q})); // R1
  AST_US_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && us_last) |=> (us_q == '0) && sec_pulse); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R6
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_stb && !sw_load) |=> (us_q == '0) && (sec_q == $past(sync_sec)) && !sec_pulse); // R5
  AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> {min_q, sec_q, us_q} == $past(bus_wdata)); // R9
  AST_DAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && day_q != '0) |=> day_q != '0); // R3

endmodule

// File: tb/time_of_year_counter_bench.sv
module time_of_year_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0, leap_year = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sync_stb = 1'b0;
  logic [8:0]  sync_day = '0;
  logic [4:0]  sync_hour = '0;
  logic [5:0]  sync_min = '0, sync_sec = '0;
  logic        sec_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  time_of_year_counter u_time_of_year_counter (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .leap_year(leap_year),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_stb(sync_stb), .sync_day(sync_day), .sync_hour(sync_hour),
    .sync_min(sync_min), .sync_sec(sync_sec), .sec_pulse(sec_pulse));

  typedef struct packed {
    logic [45:0] start;
    logic        leap;
    logic [7:0]  n;
    logic [45:0] exp;
  } vec_t;

  // tag = {day9, hour5, min6, sec6, us20}
  localparam vec_t VECS [9] = '{
    '{{9'd1,5'd0,6'd0,6'd0,20'd0},            1'b0, 8'd5, {9'd1,5'd0,6'd0,6'd0,20'd5}},       // R1
    '{{9'd1,5'd0,6'd0,6'd0,20'd999998},       1'b0, 8'd2, {9'd1,5'd0,6'd0,6'd1,20'd0}},       // R2
    '{{9'd1,5'd0,6'd0,6'd59,20'd999999},      1'b0, 8'd1, {9'd1,5'd0,6'd1,6'd0,20'd0}},       // R2
    '{{9'd1,5'd0,6'd59,6'd59,20'd999999},     1'b0, 8'd1, {9'd1,5'd1,6'd0,6'd0,20'd0}},       // R2
    '{{9'd1,5'd23,6'd59,6'd59,20'd999999},    1'b0, 8'd1, {9'd2,5'd0,6'd0,6'd0,20'd0}},       // R3
    '{{9'd365,5'd23,6'd59,6'd59,20'd999999},  1'b0, 8'd1, {9'd1,5'd0,6'd0,6'd0,20'd0}},       // R3
    '{{9'd365,5'd23,6'd59,6'd59,20'd999999},  1'b1, 8'd1, {9'd366,5'd0,6'd0,6'd0,20'd0}},     // R3
    '{{9'd366,5'd23,6'd59,6'd59,20'd999999},  1'b1, 8'd1, {9'd1,5'd0,6'd0,6'd0,20'd0}},       // R3
    '{{9'd100,5'd12,6'd30,6'd15,20'd500000},  1'b0, 8'd3, {9'd100,5'd12,6'd30,6'd15,20'd500003}} // R1
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_tag(input logic [45:0] t);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = {18'd0, t[45:32]};
    @(negedge clk); bus_addr = 1'b0; bus_wdata = t[31:0];
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic read_tag(output logic [45:0] t);
    logic [31:0] lo;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 1'b0; #1 lo = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 1'b1; #1 t = {bus_rdata[13:0], lo};
    bus_addr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1'b1;
    end
    @(negedge clk); tick_us = 1'b0;
  endtask

  task automatic set_sync(input logic [8:0] d, input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
    sync_day = d; sync_hour = h; sync_min = m; sync_sec = s;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [45:0] t, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    #1 chk("R8 pulse", 64'(sec_pulse), 64'd0);
    @(negedge clk); bus_addr = 1'b1; #1 chk("R8 snap", 64'(bus_rdata), 64'd0);
    bus_addr = 1'b0;
    read_tag(t);
    chk("R8 tag", 64'(t), 64'({9'd1, 37'd0}));

    foreach (VECS[i]) begin
      leap_year = VECS[i].leap;
      load_tag(VECS[i].start);
      ticks(int'(VECS[i].n));
      read_tag(t);
      chk($sformatf("R1/R2/R3 vector %0d", i), 64'(t), 64'(VECS[i].exp));
    end
    leap_year = 1'b0;

    // R1 hold without tick
    load_tag({9'd42, 5'd7, 6'd8, 6'd9, 20'd77});
    repeat (5) @(negedge clk);
    read_tag(t);
    chk("R1 hold", 64'(t), 64'({9'd42, 5'd7, 6'd8, 6'd9, 20'd77}));

    // R4 staging write alone leaves count
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = {18'd0, 9'd300, 5'd20};
    @(negedge clk); bus_wr = 1'b0; bus_addr = 1'b0;
    read_tag(t);
    chk("R4 stage only", 64'(t), 64'({9'd42, 5'd7, 6'd8, 6'd9, 20'd77}));

    // R5 sync wins over tick
    load_tag({9'd10, 5'd5, 6'd6, 6'd7, 20'd12345});
    @(negedge clk); set_sync(9'd200, 5'd3, 6'd4, 6'd5); sync_stb = 1'b1; tick_us = 1'b1;
    @(negedge clk); sync_stb = 1'b0; tick_us = 1'b0;
    read_tag(t);
    chk("R5 sync over tick", 64'(t), 64'({9'd200, 5'd3, 6'd4, 6'd5, 20'd0}));

    // R5/R6 sync at rollover suppresses pulse
    load_tag({9'd10, 5'd5, 6'd6, 6'd7, 20'd999999});
    @(negedge clk); set_sync(9'd2, 5'd1, 6'd2, 6'd3); sync_stb = 1'b1; tick_us = 1'b1;
    @(negedge clk); sync_stb = 1'b0; tick_us = 1'b0;
    #1 chk("R5 no pulse on sync", 64'(sec_pulse), 64'd0);
    read_tag(t);
    chk("R5 sync at rollover", 64'(t), 64'({9'd2, 5'd1, 6'd2, 6'd3, 20'd0}));

    // R9 software write wins over sync and tick
    load_tag({9'd50, 5'd6, 6'd1, 6'd1, 20'd1});
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = {6'd11, 6'd22, 20'd333};
    set_sync(9'd9, 5'd9, 6'd9, 6'd9); sync_stb = 1'b1; tick_us = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sync_stb = 1'b0; tick_us = 1'b0;
    read_tag(t);
    chk("R9 write wins", 64'(t), 64'({9'd50, 5'd6, 6'd11, 6'd22, 20'd333}));

    // R6 pulse timing
    load_tag({9'd5, 5'd0, 6'd0, 6'd0, 20'd999999});
    #1 chk("R6 pulse idle", 64'(sec_pulse), 64'd0);
    @(negedge clk); tick_us = 1'b1;
    @(negedge clk); tick_us = 1'b0;
    #1 chk("R6 pulse high", 64'(sec_pulse), 64'd1);
    @(negedge clk); #1 chk("R6 pulse one cycle", 64'(sec_pulse), 64'd0);

    // R7 coherent snapshot
    load_tag({9'd20, 5'd3, 6'd59, 6'd59, 20'd999999});
    @(negedge clk); bus_rd = 1'b1; bus_addr = 1'b0;
    @(negedge clk); bus_rd = 1'b0; tick_us = 1'b1;
    @(negedge clk); tick_us = 1'b0; bus_addr = 1'b1;
    #1 chk("R7 stale high", 64'(bus_rdata), 64'({18'd0, 9'd20, 5'd3}));
    bus_addr = 1'b0;
    #1 chk("R7 live low", 64'(bus_rdata), 64'd0);
    read_tag(t2);
    chk("R7 fresh tag", 64'(t2), 64'({9'd20, 5'd4, 6'd0, 6'd0, 20'd0}));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule